// File: doc/BRIEF.md
# Multi-Channel Event Readout Merger

This block gathers one event from a row of twelve detector channels and hands it to the host as a framed serial record. A single readout request starts a fixed sequence. First all twelve serial ADCs are selected together and clocked from one shared serial clock at one sixth of the system clock. Each ADC returns one 12-bit conversion, and the block captures all twelve in parallel. Next the block reads a 3-bit reply from each of the twelve front-end chips. These replies come back at half the system clock rate and carry an accept flag and a 2-bit range code.

The block then builds one 15-bit record per channel and sends the records at the full system clock rate over two output lanes. Lane 0 carries the even channels and lane 1 the odd channels. Each lane frame begins with a start bit. A busy output covers the whole sequence, and a request that arrives while busy is high has no effect. The bits of one event therefore leave the block exactly 169 cycles after the request is taken.

Top module: `evt_merge_top`

## Requirements
- R1: While reset is held and right after it is released, busy, adc_sclk, fe_rd, fe_clk and both lanes are 0, and adc_csn is 1.
- R2: A request sampled high while busy is low raises busy on the next clock edge. Busy then stays high for exactly 169 cycles: 72 for the ADC read, 6 for the front-end read and 91 for the output frame.
- R3: During the first 72 busy cycles, adc_csn is low and adc_sclk repeats a pattern of 3 cycles low followed by 3 cycles high, twelve times. Each ADC bit is captured as adc_sclk rises, MSB first. Outside these cycles adc_csn is 1 and adc_sclk is 0.
- R4: In busy cycles 72 to 77, fe_rd is high and fe_clk is high in every second cycle, starting in the second one. Three reply bits per chip are captured as fe_clk falls, in the order accept flag, range bit 1, range bit 0. Outside these cycles fe_rd and fe_clk are 0.
- R5: In busy cycle 78, both lanes carry a start bit of 1. The frame body follows at one bit per system clock.
- R6: Lane 0 carries channels 0, 2, 4, 6, 8 and 10, and lane 1 carries channels 1, 3, 5, 7, 9 and 11, each in ascending order.
- R7: Each channel record is 15 bits, sent in this order: accept flag, then the range code MSB first, then the 12-bit ADC code MSB first.
- R8: A channel whose accept flag is 0 is still sent in its slot, with a 0 in the flag position.
- R9: A request sampled while busy is high neither restarts the sequence nor adds a frame. This holds even in the last busy cycle.
- R10: Both lanes are 0 outside the 91 frame cycles, and busy falls in the cycle right after the last frame bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Readout request, sampled on the rising clock edge |
| adc_sdo | input | 12 | Serial data from each ADC, one bit per channel |
| fe_sdo | input | 12 | Serial reply from each front-end chip, one bit per channel |
| adc_sclk | output | 1 | Shared ADC serial clock, system clock divided by 6 |
| adc_csn | output | 1 | Shared ADC select, active low |
| fe_rd | output | 1 | Front-end reply window |
| fe_clk | output | 1 | Front-end reply clock, half the system rate |
| busy | output | 1 | High from request acceptance until the last frame bit has left |
| out_lane | output | 2 | Host serial lanes: bit 0 even channels, bit 1 odd channels |

## Verification
All timing is counted from the first cycle in which busy is high, which is the cycle after the request edge. ADC pins follow their pattern in cycles 0 to 71, front-end pins in cycles 72 to 77, the start bit appears in cycle 78, and busy must fall in cycle 169. The bench samples every output on the falling clock edge and keeps a cycle counter, so each check compares against the exact cycle the requirement gives. The serial device models change their data half a cycle after the clock edge that shifts them, which keeps the data clear of the sampling edges. Expected frames are queued when each request is issued and compared bit by bit as the lanes deliver them.

// File: rtl/evt_merge_pkg.sv
package evt_merge_pkg;

    localparam int DEF_CH    = 12;
    localparam int DEF_ADC_W = 12;
    localparam int DEF_RNG_W = 2;
    localparam int DEF_DIV   = 6;
    localparam int DEF_LANES = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADC  = 2'd1,
        PH_FE   = 2'd2,
        PH_OUT  = 2'd3
    } phase_e;

    typedef struct packed {
        logic adc_shift;
        logic fe_shift;
        logic emit;
    } strobe_t;

    function automatic int frame_bits(input int nch, input int lanes, input int rec_w);
        return 1 + (nch / lanes) * rec_w;
    endfunction

    function automatic int count_bits(input int max_value);
        return $clog2(max_value + 1);
    endfunction

endpackage

// File: rtl/evt_seq.sv
module evt_seq
    import evt_merge_pkg::*;
#(
    parameter int ADC_W   = DEF_ADC_W,
    parameter int FE_BITS = DEF_RNG_W + 1,
    parameter int DIV     = DEF_DIV,
    parameter int FRAME_W = 91,
    parameter int CNT_W   = count_bits(FRAME_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    output logic             busy,
    output logic             adc_csn,
    output logic             adc_sclk,
    output logic             fe_rd,
    output logic             fe_clk,
    output strobe_t          strb,
    output logic [CNT_W-1:0] out_idx
);

    localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF  = DIV / 2;

    phase_e           phase;
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] cnt;
    logic             div_last;
    logic             out_last;

    assign div_last = (div == DIV_W'(DIV - 1));
    assign out_last = (phase == PH_OUT) && (cnt == CNT_W'(FRAME_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            div   <= '0;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (req) begin
                        phase <= PH_ADC;
                        div   <= '0;
                        cnt   <= '0;
                    end
                end
                PH_ADC: begin
                    if (div_last) begin
                        div <= '0;
                        if (cnt == CNT_W'(ADC_W - 1)) begin
                            cnt   <= '0;
                            phase <= PH_FE;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end else begin
                        div <= div + DIV_W'(1);
                    end
                end
                PH_FE: begin
                    if (div[0]) begin
                        div <= '0;
                        if (cnt == CNT_W'(FE_BITS - 1)) begin
                            cnt   <= '0;
                            phase <= PH_OUT;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end else begin
                        div <= div + DIV_W'(1);
                    end
                end
                PH_OUT: begin
                    if (out_last) begin
                        cnt   <= '0;
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        busy           = (phase != PH_IDLE);
        adc_csn        = (phase != PH_ADC);
        adc_sclk       = (phase == PH_ADC) && (div >= DIV_W'(HALF));
        fe_rd          = (phase == PH_FE);
        fe_clk         = (phase == PH_FE) && div[0];
        strb.adc_shift = (phase == PH_ADC) && (div == DIV_W'(HALF - 1));
        strb.fe_shift  = (phase == PH_FE) && div[0];
        strb.emit      = (phase == PH_OUT);
        out_idx        = cnt;
    end

    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && !out_last) |=> busy) else $error("busy dropped early"); // R2

    AST_SCLK_SELECTED: assert property (@(posedge clk) disable iff (rst)
        adc_sclk |-> !adc_csn) else $error("adc clock without select"); // R3

    AST_SELECT_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_csn) |-> !adc_sclk) else $error("adc clock high at select"); // R3

    AST_FE_CLK_WINDOW: assert property (@(posedge clk) disable iff (rst)
        fe_clk |-> fe_rd) else $error("fe clock outside window"); // R4

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |=> !(phase == PH_ADC && div == '0 && cnt == '0))
        else $error("sequence restarted while busy"); // R9

endmodule

// File: rtl/evt_capture.sv
module evt_capture #(
    parameter int NUM_CH = 12,
    parameter int W      = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  shift,
    input  logic [NUM_CH-1:0]     sdi,
    output logic [NUM_CH*W-1:0]   words
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        logic [W-1:0] shreg;

        always_ff @(posedge clk) begin
            if (rst) begin
                shreg <= '0;
            end else if (shift) begin
                shreg <= {shreg[W-2:0], sdi[ch]};
            end
        end

        assign words[ch*W +: W] = shreg;
    end

endmodule

// File: rtl/evt_lane_fmt.sv
module evt_lane_fmt #(
    parameter int NUM_CH    = 12,
    parameter int NUM_LANES = 2,
    parameter int ADC_W     = 12,
    parameter int FE_BITS   = 3,
    parameter int FRAME_W   = 91,
    parameter int CNT_W     = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        emit,
    input  logic [CNT_W-1:0]            idx,
    input  logic [NUM_CH*ADC_W-1:0]     codes,
    input  logic [NUM_CH*FE_BITS-1:0]   flags,
    output logic [NUM_LANES-1:0]        lane
);

    localparam int REC_W = FE_BITS + ADC_W;
    localparam int PER   = NUM_CH / NUM_LANES;

    logic [CNT_W-1:0] sel;
    assign sel = CNT_W'(FRAME_W - 1) - idx;

    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
        logic [FRAME_W-1:0] frame;

        assign frame[FRAME_W-1] = 1'b1;

        for (genvar k = 0; k < PER; k++) begin : g_slot
            localparam int CH = k * NUM_LANES + ln;
            assign frame[FRAME_W-2-k*REC_W -: REC_W] =
                {flags[CH*FE_BITS +: FE_BITS], codes[CH*ADC_W +: ADC_W]};
        end

        assign lane[ln] = emit && frame[sel];
    end

    AST_START_BIT: assert property (@(posedge clk) disable iff (rst)
        (emit && idx == '0) |-> (&lane)) else $error("missing start bit"); // R5

endmodule

// File: rtl/evt_merge_top.sv
module evt_merge_top
    import evt_merge_pkg::*;
#(
    parameter int NUM_CH    = DEF_CH,
    parameter int ADC_W     = DEF_ADC_W,
    parameter int RNG_W     = DEF_RNG_W,
    parameter int SCLK_DIV  = DEF_DIV,
    parameter int NUM_LANES = DEF_LANES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_req,
    input  logic [NUM_CH-1:0]    adc_sdo,
    input  logic [NUM_CH-1:0]    fe_sdo,
    output logic                 adc_sclk,
    output logic                 adc_csn,
    output logic                 fe_rd,
    output logic                 fe_clk,
    output logic                 busy,
    output logic [NUM_LANES-1:0] out_lane
);

    localparam int FE_BITS = RNG_W + 1;
    localparam int REC_W   = FE_BITS + ADC_W;
    localparam int FRAME_W = frame_bits(NUM_CH, NUM_LANES, REC_W);
    localparam int CNT_W   = count_bits(FRAME_W);

    strobe_t                     strb;
    logic [CNT_W-1:0]            out_idx;
    logic [NUM_CH*ADC_W-1:0]     codes;
    logic [NUM_CH*FE_BITS-1:0]   flags;

    evt_seq #(
        .ADC_W   (ADC_W),
        .FE_BITS (FE_BITS),
        .DIV     (SCLK_DIV),
        .FRAME_W (FRAME_W),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (rd_req),
        .busy     (busy),
        .adc_csn  (adc_csn),
        .adc_sclk (adc_sclk),
        .fe_rd    (fe_rd),
        .fe_clk   (fe_clk),
        .strb     (strb),
        .out_idx  (out_idx)
    );

    evt_capture #(
        .NUM_CH (NUM_CH),
        .W      (ADC_W)
    ) u_adc_cap (
        .clk   (clk),
        .rst   (rst),
        .shift (strb.adc_shift),
        .sdi   (adc_sdo),
        .words (codes)
    );

    evt_capture #(
        .NUM_CH (NUM_CH),
        .W      (FE_BITS)
    ) u_fe_cap (
        .clk   (clk),
        .rst   (rst),
        .shift (strb.fe_shift),
        .sdi   (fe_sdo),
        .words (flags)
    );

    evt_lane_fmt #(
        .NUM_CH    (NUM_CH),
        .NUM_LANES (NUM_LANES),
        .ADC_W     (ADC_W),
        .FE_BITS   (FE_BITS),
        .FRAME_W   (FRAME_W),
        .CNT_W     (CNT_W)
    ) u_fmt (
        .clk   (clk),
        .rst   (rst),
        .emit  (strb.emit),
        .idx   (out_idx),
        .codes (codes),
        .flags (flags),
        .lane  (out_lane)
    );

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (out_lane == '0 && adc_csn && !fe_rd))
        else $error("activity while idle"); // R10

endmodule

// File: tb/tb_evt_merge_top.sv
module tb_evt_merge_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 12;
    localparam int FW         = 91;
    localparam int BUSY_LEN   = 169;

    typedef struct packed {
        logic [FW-1:0] l0;
        logic [FW-1:0] l1;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            rd_req = 1'b0;
    logic [NCH-1:0]  adc_sdo = '0;
    logic [NCH-1:0]  fe_sdo = '0;
    logic            adc_sclk, adc_csn, fe_rd, fe_clk, busy;
    logic [1:0]      out_lane;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int req_cyc = 0;
    int frames = 0;
    int events = 0;

    logic [11:0] adc_val [NCH];
    logic [2:0]  fe_val  [NCH];
    logic [11:0] nxt_adc [NCH];
    logic [2:0]  nxt_fe  [NCH];
    exp_t        exp_q [$];

    evt_merge_top dut (
        .clk      (clk),
        .rst      (rst),
        .rd_req   (rd_req),
        .adc_sdo  (adc_sdo),
        .fe_sdo   (fe_sdo),
        .adc_sclk (adc_sclk),
        .adc_csn  (adc_csn),
        .fe_rd    (fe_rd),
        .fe_clk   (fe_clk),
        .busy     (busy),
        .out_lane (out_lane)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic exp_t build_frames();
        exp_t e;
        e.l0 = '0;
        e.l1 = '0;
        e.l0[FW-1] = 1'b1;
        e.l1[FW-1] = 1'b1;
        for (int k = 0; k < NCH/2; k++) begin
            e.l0[FW-2-k*15 -: 15] = {fe_val[2*k],   adc_val[2*k]};
            e.l1[FW-2-k*15 -: 15] = {fe_val[2*k+1], adc_val[2*k+1]};
        end
        return e;
    endfunction

    // ADC models: data changes half a cycle after the shifting clock edge
    initial begin
        forever begin
            @(negedge adc_csn);
            @(negedge clk);
            for (int ch = 0; ch < NCH; ch++) adc_sdo[ch] = adc_val[ch][11];
            for (int b = 10; b >= 0; b--) begin
                @(negedge adc_sclk);
                @(negedge clk);
                for (int ch = 0; ch < NCH; ch++) adc_sdo[ch] = adc_val[ch][b];
            end
        end
    end

    // Front-end models: reply order accept, range[1], range[0]
    initial begin
        forever begin
            @(posedge fe_rd);
            @(negedge clk);
            for (int ch = 0; ch < NCH; ch++) fe_sdo[ch] = fe_val[ch][2];
            for (int b = 1; b >= 0; b--) begin
                @(negedge fe_clk);
                @(negedge clk);
                for (int ch = 0; ch < NCH; ch++) fe_sdo[ch] = fe_val[ch][b];
            end
        end
    end

    // Driver: waits for idle, loads the staged data, queues the expected frames
    task automatic run_event(input bit extra);
        @(negedge clk);
        while (busy) @(negedge clk);
        for (int ch = 0; ch < NCH; ch++) begin
            adc_val[ch] = nxt_adc[ch];
            fe_val[ch]  = nxt_fe[ch];
        end
        exp_q.push_back(build_frames());
        events++;
        rd_req  = 1'b1;
        req_cyc = cyc;
        @(negedge clk);
        rd_req = 1'b0;
        if (extra) begin
            // R9: one request during the ADC read, one in the last busy cycle
            while (cyc != req_cyc + 31) @(negedge clk);
            rd_req = 1'b1;
            @(negedge clk);
            rd_req = 1'b0;
            while (cyc != req_cyc + BUSY_LEN) @(negedge clk);
            rd_req = 1'b1;
            @(negedge clk);
            rd_req = 1'b0;
        end
    endtask

    // Monitor and scoreboard
    bit            busy_prev = 1'b0;
    bit            in_frame = 1'b0;
    bit            bad3, bad4;
    int            b0 = 0;
    int            pos = 0;
    exp_t          cur;
    logic [FW-1:0] got0, got1;

    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (busy && !busy_prev) begin
                    b0   = cyc;
                    bad3 = 1'b0;
                    bad4 = 1'b0;
                    chk(cyc == req_cyc + 1, "R2 busy rise cycle",
                        FW'(cyc - req_cyc), FW'(1));
                end
                if (busy) begin
                    int c;
                    c = cyc - b0;
                    if (c < 72) begin
                        if (adc_csn !== 1'b0 || adc_sclk !== ((c % 6) >= 3)) bad3 = 1'b1;
                        if (fe_rd !== 1'b0 || fe_clk !== 1'b0) bad4 = 1'b1;
                    end else if (c < 78) begin
                        if (adc_csn !== 1'b1 || adc_sclk !== 1'b0) bad3 = 1'b1;
                        if (fe_rd !== 1'b1 || fe_clk !== ((c - 72) % 2 == 1)) bad4 = 1'b1;
                    end else begin
                        if (adc_csn !== 1'b1 || adc_sclk !== 1'b0) bad3 = 1'b1;
                        if (fe_rd !== 1'b0 || fe_clk !== 1'b0) bad4 = 1'b1;
                    end
                end
                if (!busy && busy_prev) begin
                    chk(cyc - b0 == BUSY_LEN, "R2 busy length",
                        FW'(cyc - b0), FW'(BUSY_LEN));
                    chk(!bad3, "R3 adc clock and select pattern", FW'(bad3), FW'(0));
                    chk(!bad4, "R4 front-end read pattern", FW'(bad4), FW'(0));
                    chk(out_lane == 2'b00 && !in_frame, "R10 lanes quiet after frame",
                        FW'(out_lane), FW'(0));
                end
                busy_prev = busy;

                if (!in_frame && out_lane != 2'b00) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R9 unexpected frame", FW'(out_lane), FW'(0));
                    end else begin
                        cur      = exp_q.pop_front();
                        in_frame = 1'b1;
                        pos      = 0;
                        got0     = '0;
                        got1     = '0;
                        chk(busy && (cyc - b0 == 78), "R5 start bit cycle",
                            FW'(cyc - b0), FW'(78));
                    end
                end
                if (in_frame) begin
                    got0[FW-1-pos] = out_lane[0];
                    got1[FW-1-pos] = out_lane[1];
                    pos++;
                    if (pos == FW) begin
                        in_frame = 1'b0;
                        frames++;
                        chk(got0 == cur.l0, "R6 R7 R8 lane 0 frame", got0, cur.l0);
                        chk(got1 == cur.l1, "R6 R7 R8 lane 1 frame", got1, cur.l1);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int ch = 0; ch < NCH; ch++) begin
            adc_val[ch] = '0;
            fe_val[ch]  = '0;
        end
        repeat (4) @(negedge clk);
        // R1: outputs during reset
        chk(busy == 1'b0 && adc_csn == 1'b1 && adc_sclk == 1'b0 && fe_rd == 1'b0 &&
            fe_clk == 1'b0 && out_lane == 2'b00, "R1 reset state",
            FW'({busy, adc_csn, adc_sclk, fe_rd, fe_clk, out_lane}), FW'(7'b0100000));
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && adc_csn == 1'b1 && out_lane == 2'b00, "R1 after reset",
            FW'({busy, adc_csn, out_lane}), FW'(4'b0100));

        // counting pattern, all accepted
        for (int ch = 0; ch < NCH; ch++) begin
            nxt_adc[ch] = 12'(ch * 273 + 5);
            nxt_fe[ch]  = 3'(4 | (ch % 4));
        end
        run_event(1'b0);

        // all ones
        for (int ch = 0; ch < NCH; ch++) begin
            nxt_adc[ch] = 12'hFFF;
            nxt_fe[ch]  = 3'b111;
        end
        run_event(1'b0);

        // R8: odd channels and channel 4 not accepted
        for (int ch = 0; ch < NCH; ch++) begin
            nxt_adc[ch] = 12'hA5A ^ 12'(ch);
            nxt_fe[ch]  = {(ch % 2 == 0) && (ch != 4), 2'(ch % 4)};
        end
        run_event(1'b0);

        // all zero: only the start bits are set
        for (int ch = 0; ch < NCH; ch++) begin
            nxt_adc[ch] = '0;
            nxt_fe[ch]  = '0;
        end
        run_event(1'b0);

        // random data with requests while busy (R9)
        for (int ch = 0; ch < NCH; ch++) begin
            nxt_adc[ch] = 12'($urandom);
            nxt_fe[ch]  = 3'($urandom);
        end
        run_event(1'b1);

        // back to back, issued the cycle busy falls
        for (int ch = 0; ch < NCH; ch++) begin
            nxt_adc[ch] = 12'($urandom);
            nxt_fe[ch]  = 3'($urandom);
        end
        run_event(1'b0);

        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (300) @(negedge clk);
        // R9: one frame per accepted request, nothing extra
        chk(frames == events && exp_q.size() == 0, "R9 frame count",
            FW'(frames), FW'(events));
        chk(busy == 1'b0 && out_lane == 2'b00, "R10 idle after run",
            FW'({busy, out_lane}), FW'(0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule